// File: doc/BRIEF.md
# I2C Register-Write Slave

This block is a receive-only slave on a two-wire serial control bus that runs in standard mode. It samples the clock and data lines against a fast system clock and finds start and stop conditions. It then compares the first byte of each transfer against a fixed 7-bit device address with a write direction bit. When the address matches, the next byte sets a register pointer. Every byte after that produces a one-cycle register write strobe, with the pointer as the address and the byte as the data. The pointer then steps to the next register.

The block acknowledges every byte that follows a matched address. It never refuses a byte after a match, so a host can send a single byte, a word or a block of any length in one auto-incrementing burst. The host is responsible for sending commands in a sensible order. A transfer addressed to another device, or one that asks to read, is not acknowledged. The block then releases the data line and stays silent until the next start or stop. Data is driven open-drain: `sda_oe_o` high means the pad pulls the line low.

Top module: `i2c_regwr_slave`

## Requirements
- R1: While `rst_ni` is low, and after its release with an idle bus, `sda_oe_o` and `wr_en_o` are 0.
- R2: A start is SDA falling while SCL is high, and it begins the address phase from any state. A stop is SDA rising while SCL is high, and it ends the transfer. Bytes clocked after a stop and without a new start are neither acknowledged nor written.
- R3: The first byte after a start is acknowledged only when its bits [7:1] equal `DEV_ADDR` and bit [0] (R/W) is 0. Otherwise the block holds `sda_oe_o` at 0 until the next start or stop.
- R4: `sda_oe_o` is 0 throughout the eight data bits of every byte. It is 1 from the SCL fall that ends bit 8 until the SCL fall that ends the ninth (acknowledge) clock. It changes only while SCL is low.
- R5: The byte after a matched address loads the register pointer and causes no write.
- R6: Each later byte gives a `wr_en_o` pulse in which `wr_addr_o` is the pointer and `wr_data_o` is the byte. The pointer then increments and wraps from all-ones to 0.
- R7: After a matched address, every byte up to the next start or stop is acknowledged. There is no length limit.
- R8: A repeated start in the middle of a transfer discards the partial state and re-enters address matching. The register pointer must then be set again.
- R9: `wr_en_o` is exactly one system clock wide, with one pulse per data byte. It rises only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 10x the bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_en_o | output | 1 | Register write strobe, one clock wide |
| wr_addr_o | output | REG_AW | Register address for the write |
| wr_data_o | output | 8 | Register data for the write |

## Verification
A completed data byte raises the write strobe and the acknowledge drive on the same system clock, at the SCL fall that ends bit 8. Bursts of several data bytes produce this case many times. The bench checks both: a monitor run on every clock compares each strobe against a queue of expected writes, and the bus task samples the wired-AND data line during the ninth clock. A repeated start placed right after an acknowledge tests the second collision, where a new start arrives while the pointer and the acknowledge state are still live. The bench judges it by the next address being acknowledged or refused and by the absence of stray writes.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUBA,
    ST_DATA,
    ST_IGNORE
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;  // idle bus is high
        else if (g == 0) sync_q[g] <= d_i;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_i,
  output logic [7:0] byte_o,
  output logic       byte_done_o,
  output logic       ack_end_o
);
  logic [7:0] shift_q;
  logic [3:0] cnt_q;
  logic       in_ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= '0;
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
    end else if (scl_rise_i && !in_ack_q && cnt_q < 4'd8) begin
      shift_q <= {shift_q[6:0], sda_i};
      cnt_q   <= cnt_q + 4'd1;
    end else if (byte_done_o) begin
      in_ack_q <= 1'b1;
    end else if (ack_end_o) begin
      in_ack_q <= 1'b0;
      cnt_q    <= '0;
    end
  end

  assign byte_o      = shift_q;
  assign byte_done_o = !clr_i && scl_fall_i && !in_ack_q && cnt_q == 4'd8;
  assign ack_end_o   = !clr_i && scl_fall_i && in_ack_q;
endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave
  import i2c_regwr_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h34,
  parameter int unsigned REG_AW      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] lvl, rise, fall;
  logic [NLINES-1:0] pins;
  assign pins = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < NLINES; g++) begin : g_line
      i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (pins[g]),
        .lvl_o (lvl[g]),
        .rise_o(rise[g]),
        .fall_o(fall[g])
      );
    end
  endgenerate

  logic bus_start, bus_stop;
  assign bus_start = lvl[0] & fall[1];
  assign bus_stop  = lvl[0] & rise[1];

  logic [7:0] rx_byte;
  logic       byte_done, ack_end;

  i2c_byte_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (bus_start | bus_stop),
    .scl_rise_i (rise[0]),
    .scl_fall_i (fall[0]),
    .sda_i      (lvl[1]),
    .byte_o     (rx_byte),
    .byte_done_o(byte_done),
    .ack_end_o  (ack_end)
  );

  slv_state_e        st_q;
  logic [REG_AW-1:0] ptr_q;
  logic              oe_q, wr_en_q;
  logic [REG_AW-1:0] wr_addr_q;
  logic [7:0]        wr_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (bus_start) begin
        st_q <= ST_ADDR;
        oe_q <= 1'b0;
      end else if (bus_stop) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else if (byte_done) begin
        unique case (st_q)
          ST_ADDR: begin
            if (rx_byte[7:1] == DEV_ADDR && !rx_byte[0]) begin
              st_q <= ST_SUBA;
              oe_q <= 1'b1;
            end else begin
              st_q <= ST_IGNORE;
            end
          end
          ST_SUBA: begin
            ptr_q <= REG_AW'(rx_byte);
            st_q  <= ST_DATA;
            oe_q  <= 1'b1;
          end
          ST_DATA: begin
            wr_en_q   <= 1'b1;
            wr_addr_q <= ptr_q;
            wr_data_q <= rx_byte;
            ptr_q     <= ptr_q + 1'b1;
            oe_q      <= 1'b1;
          end
          default: ;
        endcase
      end else if (ack_end) begin
        oe_q <= 1'b0;
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
endmodule

// File: rtl/i2c_regwr_checker.sv
module i2c_regwr_checker
  import i2c_regwr_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic       wr_en_o,
  input slv_state_e st_i
);
  AST_WR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);  // R9
  AST_WR_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> sda_oe_o);  // R7
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);  // R4
  AST_OE_FALL_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_i);  // R4
  AST_WR_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> !scl_i);  // R9
  AST_QUIET_UNSELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IGNORE || st_i == ST_IDLE) |-> !sda_oe_o);  // R3
  AST_NO_WR_BEFORE_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> st_i == ST_DATA);  // R5
endmodule

bind i2c_regwr_slave i2c_regwr_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_i   (scl_i),
  .sda_oe_o(sda_oe_o),
  .wr_en_o (wr_en_o),
  .st_i    (st_q)
);

// File: tb/test_i2c_regwr_slave.sv
module test_i2c_regwr_slave;
  localparam logic [6:0] DEV = 7'h34;
  localparam int Q = 5;  // quarter bit, in system clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_line;
  logic sda_oe, wr_en;
  logic [7:0] wr_addr, wr_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  i2c_regwr_slave #(.DEV_ADDR(DEV)) i_i2c_regwr_slave (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference: every strobe must match the next expected write (R6, R9)
  always @(negedge clk) begin
    cyc++;
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected write addr", int'(wr_addr), -1);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check({wr_addr, wr_data} == e, "R6", "write addr/data",
              int'({wr_addr, wr_data}), int'(e));
      end
    end
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      check(1'b0, "R7", "watchdog expired", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wq(int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_drv = 1'b1; wq();
    scl = 1'b1; wq();
    sda_drv = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bstop();
    sda_drv = 1'b0; wq();
    scl = 1'b1; wq();
    sda_drv = 1'b1; wq();
  endtask

  task automatic bsend(logic [7:0] b, bit exp_ack, string req);
    bit quiet = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wq();
      scl = 1'b1; wq();
      if (sda_oe) quiet = 1'b0;
      wq();
      scl = 1'b0; wq();
    end
    check(quiet, "R4", "oe during data bits", 1, 0);
    sda_drv = 1'b1; wq();
    scl = 1'b1; wq();
    check((sda_line == 1'b0) == exp_ack, req, "ack slot", int'(!sda_line), int'(exp_ack));
    wq();
    scl = 1'b0; wq();
    wq(2);
    check(sda_oe == 1'b0, "R4", "release after ack", int'(sda_oe), 0);
  endtask

  task automatic expect_wr(logic [7:0] a, logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic drain(string req);
    wq(4);
    check(exp_q.size() == 0, req, "pending writes", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    wq(3);
    check(sda_oe == 1'b0 && wr_en == 1'b0, "R1", "reset outputs", int'({sda_oe, wr_en}), 0);
    rst_n = 1'b1;
    wq(10);
    check(sda_oe == 1'b0 && wr_en == 1'b0, "R1", "idle after reset", int'({sda_oe, wr_en}), 0);

    // basic burst
    bstart();
    bsend({DEV, 1'b0}, 1'b1, "R3");
    bsend(8'h10, 1'b1, "R5");
    expect_wr(8'h10, 8'hA5); bsend(8'hA5, 1'b1, "R7");
    expect_wr(8'h11, 8'h3C); bsend(8'h3C, 1'b1, "R7");
    expect_wr(8'h12, 8'h7E); bsend(8'h7E, 1'b1, "R7");
    bstop();
    drain("R6");

    // other device: silent
    bstart();
    bsend({7'h22, 1'b0}, 1'b0, "R3");
    bsend(8'h05, 1'b0, "R3");
    bsend(8'h99, 1'b0, "R3");
    bstop();
    drain("R3");

    // read direction is not taken
    bstart();
    bsend({DEV, 1'b1}, 1'b0, "R3");
    bsend(8'h44, 1'b0, "R3");
    bstop();
    drain("R3");

    // pointer wrap
    bstart();
    bsend({DEV, 1'b0}, 1'b1, "R3");
    bsend(8'hFE, 1'b1, "R5");
    expect_wr(8'hFE, 8'h01); bsend(8'h01, 1'b1, "R6");
    expect_wr(8'hFF, 8'h02); bsend(8'h02, 1'b1, "R6");
    expect_wr(8'h00, 8'h03); bsend(8'h03, 1'b1, "R6");
    bstop();
    drain("R6");

    // repeated start re-enters address match
    bstart();
    bsend({DEV, 1'b0}, 1'b1, "R3");
    bsend(8'h40, 1'b1, "R5");
    expect_wr(8'h40, 8'h11); bsend(8'h11, 1'b1, "R6");
    bstart();
    bsend({DEV, 1'b0}, 1'b1, "R8");
    bsend(8'h50, 1'b1, "R8");
    expect_wr(8'h50, 8'h22); bsend(8'h22, 1'b1, "R8");
    bstop();
    drain("R8");

    // repeated start to another device after a match
    bstart();
    bsend({DEV, 1'b0}, 1'b1, "R3");
    bsend(8'h60, 1'b1, "R5");
    expect_wr(8'h60, 8'h33); bsend(8'h33, 1'b1, "R6");
    bstart();
    bsend({7'h35, 1'b0}, 1'b0, "R8");
    bsend(8'h77, 1'b0, "R8");
    bstop();
    drain("R8");

    // bytes after a stop without a new start
    bstart();
    bsend({DEV, 1'b0}, 1'b1, "R3");
    bsend(8'h70, 1'b1, "R5");
    bstop();
    sda_drv = 1'b1; scl = 1'b0; wq();
    bsend(8'h12, 1'b0, "R2");
    bsend(8'h34, 1'b0, "R2");
    bstop();
    drain("R2");

    // long burst
    bstart();
    bsend({DEV, 1'b0}, 1'b1, "R3");
    bsend(8'h80, 1'b1, "R5");
    for (int k = 0; k < 20; k++) begin
      expect_wr(8'(8'h80 + k), 8'(k * 7 + 1));
      bsend(8'(k * 7 + 1), 1'b1, "R7");
    end
    bstop();
    drain("R7");

    wq(10);
    check(sda_oe == 1'b0 && wr_en == 1'b0, "R2", "idle after stop", int'({sda_oe, wr_en}), 0);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule